// File: doc/BRIEF.md
# Integer Instruction Execute Unit

This block takes one 32-bit instruction word together with the values of its two source registers. It works out what the instruction asks for and returns a 32-bit result, the index of the register to write and a write strobe. It handles the register-register arithmetic and logic group: wrapping add and subtract, OR, XOR and NOR. It handles the three shifts by a constant held in the instruction. It handles the immediate group: add with a sign-extended constant, AND and OR with a zero-extended constant, and placing a constant in the upper half-word.

The selection comes from the real opcode and function fields of the instruction word, not from a separate select code. Each immediate form applies its own kind of extension. An encoding outside the supported set raises an illegal-instruction flag and produces no write. Decode and execute are combinational. One output register stage holds the result, so each answer appears one clock after its instruction is presented.

Top module: `insn_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs are cleared at that edge: result 0, destination 0, write strobe 0 and illegal flag 0.
- R2: The outputs after a rising edge describe the instruction and operands that were sampled at that edge. This is a latency of exactly one clock.
- R3: With opcode 0x00 (bits 31:26), function 0x21 (bits 5:0) gives rs+rt and function 0x23 gives rs-rt, both modulo 2^32, with no trap and no flag.
- R4: With opcode 0x00, function 0x25 gives rs|rt, 0x26 gives rs^rt and 0x27 gives ~(rs|rt). All register-register forms write the rd field at bits 15:11.
- R5: With opcode 0x00, function 0x00 shifts rt left by the shamt field (bits 10:6), function 0x02 shifts rt right filling with zeros, and function 0x03 shifts rt right filling with rt bit 31.
- R6: Opcode 0x09 gives rs plus the immediate (bits 15:0) sign-extended to 32 bits. All immediate forms write the rt field at bits 20:16.
- R7: Opcode 0x0C gives rs AND the zero-extended immediate, and opcode 0x0D gives rs OR the zero-extended immediate.
- R8: Opcode 0x0F gives the immediate in bits 31:16 with bits 15:0 cleared.
- R9: Any other opcode, or opcode 0x00 with any other function code, sets the illegal flag and forces result 0, destination 0 and write strobe 0.
- R10: A legal instruction whose destination field is 0 keeps its computed result but drops the write strobe. Every other legal instruction raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the register named by bits 25:21 |
| rt_val_i | input | 32 | Value of the register named by bits 20:16 |
| result_o | output | 32 | Registered result |
| dest_o | output | 5 | Registered destination register index |
| wr_en_o | output | 1 | Registered write strobe |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
The bench targets several distinct failure modes.
- Sign-bit handling: arithmetic right shifts of negative values and add-immediate with a negative constant. A design that zero-fills or zero-extends returns a large positive number instead.
- Extension mix-up: AND and OR immediates with bit 15 set. A design that sign-extends them leaks ones into the upper half.
- Shift extremes and wrap-around: shift amounts of 0 and 31 catch an off-by-one in the barrel stages, and adds and subtracts that wrap past 2^32 must come back modulo.
- Encodings and destinations: near-miss encodings such as the trapping add function and load opcodes must raise the flag rather than compute. A destination of r0 must leave the strobe low, and a design that takes the destination from the wrong field writes the wrong register.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    localparam int XLEN   = 32;
    localparam int IMMW   = 16;
    localparam int REGAW  = 5;
    localparam int OPCW   = 6;
    localparam int FUNW   = 6;
    localparam int SHW    = $clog2(XLEN);

    // instruction field positions (decoded by neighbours, so fixed)
    localparam int OPC_LSB = XLEN - OPCW;
    localparam int RS_LSB  = OPC_LSB - REGAW;
    localparam int RT_LSB  = RS_LSB - REGAW;
    localparam int RD_LSB  = RT_LSB - REGAW;
    localparam int SH_LSB  = RD_LSB - SHW;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [REGAW-1:0] regidx_t;
    typedef logic [OPCW-1:0]  opcode_t;
    typedef logic [FUNW-1:0]  func_t;
    typedef logic [IMMW-1:0]  imm_t;
    typedef logic [SHW-1:0]   shamt_t;

    localparam opcode_t OPC_REGREG = 6'h00;
    localparam opcode_t OPC_ADDIMM = 6'h09;
    localparam opcode_t OPC_ANDIMM = 6'h0C;
    localparam opcode_t OPC_ORIMM  = 6'h0D;
    localparam opcode_t OPC_UPPER  = 6'h0F;

    localparam func_t FN_SHL  = 6'h00;
    localparam func_t FN_SHRL = 6'h02;
    localparam func_t FN_SHRA = 6'h03;
    localparam func_t FN_ADD  = 6'h21;
    localparam func_t FN_SUB  = 6'h23;
    localparam func_t FN_OR   = 6'h25;
    localparam func_t FN_XOR  = 6'h26;
    localparam func_t FN_NOR  = 6'h27;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_SUB,
        OP_AND,
        OP_OR,
        OP_XOR,
        OP_NOR,
        OP_PASSB,
        OP_SHL,
        OP_SHRL,
        OP_SHRA
    } exec_op_e;

    typedef enum logic [1:0] {
        SHK_LEFT,
        SHK_RLOG,
        SHK_RARI
    } shift_kind_e;

    typedef struct packed {
        exec_op_e op;
        word_t    opnd_a;
        word_t    opnd_b;
        shamt_t   shamt;
        regidx_t  dest;
        logic     legal;
    } uop_t;

    function automatic word_t ext_signed(input imm_t imm);
        return {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    endfunction

    function automatic word_t ext_zero(input imm_t imm);
        return {{(XLEN-IMMW){1'b0}}, imm};
    endfunction

    function automatic word_t place_upper(input imm_t imm);
        return {imm, {(XLEN-IMMW){1'b0}}};
    endfunction

    function automatic logic is_shift_op(input exec_op_e op);
        return (op == OP_SHL) || (op == OP_SHRL) || (op == OP_SHRA);
    endfunction

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
    import iexu_pkg::*;
(
    input  word_t insn_i,
    input  word_t rs_val_i,
    input  word_t rt_val_i,
    output uop_t  uop_o
);

    opcode_t opc;
    func_t   fn;
    imm_t    imm;
    regidx_t rt_idx;
    regidx_t rd_idx;
    shamt_t  sh;
    logic    unused_rs_idx;

    assign opc    = insn_i[OPC_LSB +: OPCW];
    assign fn     = insn_i[0 +: FUNW];
    assign imm    = insn_i[0 +: IMMW];
    assign rt_idx = insn_i[RT_LSB +: REGAW];
    assign rd_idx = insn_i[RD_LSB +: REGAW];
    assign sh     = insn_i[SH_LSB +: SHW];
    // register index of rs is resolved outside; only its value arrives here
    assign unused_rs_idx = ^insn_i[RS_LSB +: REGAW];

    always_comb begin
        uop_o        = '0;
        uop_o.op     = OP_NONE;
        uop_o.opnd_a = rs_val_i;
        uop_o.opnd_b = rt_val_i;
        uop_o.shamt  = sh;
        uop_o.dest   = rt_idx;
        uop_o.legal  = 1'b1;
        unique case (opc)
            OPC_REGREG: begin
                uop_o.dest = rd_idx;
                unique case (fn)
                    FN_ADD:  uop_o.op = OP_ADD;
                    FN_SUB:  uop_o.op = OP_SUB;
                    FN_OR:   uop_o.op = OP_OR;
                    FN_XOR:  uop_o.op = OP_XOR;
                    FN_NOR:  uop_o.op = OP_NOR;
                    FN_SHL:  uop_o.op = OP_SHL;
                    FN_SHRL: uop_o.op = OP_SHRL;
                    FN_SHRA: uop_o.op = OP_SHRA;
                    default: uop_o.legal = 1'b0;
                endcase
            end
            OPC_ADDIMM: begin
                uop_o.op     = OP_ADD;
                uop_o.opnd_b = ext_signed(imm);
            end
            OPC_ANDIMM: begin
                uop_o.op     = OP_AND;
                uop_o.opnd_b = ext_zero(imm);
            end
            OPC_ORIMM: begin
                uop_o.op     = OP_OR;
                uop_o.opnd_b = ext_zero(imm);
            end
            OPC_UPPER: begin
                uop_o.op     = OP_PASSB;
                uop_o.opnd_b = place_upper(imm);
            end
            default: uop_o.legal = 1'b0;
        endcase
        if (!uop_o.legal) begin
            uop_o.op   = OP_NONE;
            uop_o.dest = '0;
        end
    end

endmodule

// File: rtl/iexu_shift.sv
module iexu_shift #(
    parameter int WIDTH = 32,
    parameter int AMTW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]      val_i,
    input  logic [AMTW-1:0]       amt_i,
    input  iexu_pkg::shift_kind_e kind_i,
    output logic [WIDTH-1:0]      res_o
);

    logic [WIDTH-1:0]         mirrored;
    logic [WIDTH-1:0]         pre;
    logic [WIDTH-1:0]         post_mirror;
    logic                     fill;
    logic [AMTW:0][WIDTH-1:0] stage;
    logic                     left;

    assign left = (kind_i == iexu_pkg::SHK_LEFT);
    assign fill = (kind_i == iexu_pkg::SHK_RARI) ? val_i[WIDTH-1] : 1'b0;

    // left shifts reuse the right-shift network on a bit-reversed operand
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_mirror_in
            assign mirrored[i] = val_i[WIDTH-1-i];
        end
    endgenerate

    assign pre      = left ? mirrored : val_i;
    assign stage[0] = pre;

    genvar s;
    generate
        for (s = 0; s < AMTW; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stage[s+1] = amt_i[s]
                ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]}
                : stage[s];
        end
    endgenerate

    generate
        for (i = 0; i < WIDTH; i++) begin : g_mirror_out
            assign post_mirror[i] = stage[AMTW][WIDTH-1-i];
        end
    endgenerate

    assign res_o = left ? post_mirror : stage[AMTW];

endmodule

// File: rtl/iexu_arith.sv
module iexu_arith
    import iexu_pkg::*;
(
    input  uop_t  uop_i,
    output word_t res_o
);

    word_t a;
    word_t b;
    word_t sum;
    word_t diff;

    assign a    = uop_i.opnd_a;
    assign b    = uop_i.opnd_b;
    assign sum  = a + b;
    assign diff = a - b;

    always_comb begin
        unique case (uop_i.op)
            OP_ADD:   res_o = sum;
            OP_SUB:   res_o = diff;
            OP_AND:   res_o = a & b;
            OP_OR:    res_o = a | b;
            OP_XOR:   res_o = a ^ b;
            OP_NOR:   res_o = ~(a | b);
            OP_PASSB: res_o = b;
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/insn_exec_unit.sv
module insn_exec_unit
    import iexu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] insn_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] result_o,
    output logic [4:0]  dest_o,
    output logic        wr_en_o,
    output logic        illegal_o
);

    uop_t        uop;
    word_t       arith_res;
    word_t       shift_res;
    word_t       exec_res;
    shift_kind_e sh_kind;

    iexu_decode u_decode (
        .insn_i   (insn_i),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .uop_o    (uop)
    );

    iexu_arith u_arith (
        .uop_i (uop),
        .res_o (arith_res)
    );

    always_comb begin
        unique case (uop.op)
            OP_SHRL: sh_kind = SHK_RLOG;
            OP_SHRA: sh_kind = SHK_RARI;
            default: sh_kind = SHK_LEFT;
        endcase
    end

    iexu_shift #(
        .WIDTH (XLEN),
        .AMTW  (SHW)
    ) u_shift (
        .val_i  (uop.opnd_b),
        .amt_i  (uop.shamt),
        .kind_i (sh_kind),
        .res_o  (shift_res)
    );

    assign exec_res = is_shift_op(uop.op) ? shift_res : arith_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o  <= '0;
            dest_o    <= '0;
            wr_en_o   <= 1'b0;
            illegal_o <= 1'b0;
        end else begin
            result_o  <= uop.legal ? exec_res : '0;
            dest_o    <= uop.legal ? uop.dest : '0;
            wr_en_o   <= uop.legal && (uop.dest != '0);
            illegal_o <= !uop.legal;
        end
    end

endmodule

// File: rtl/insn_exec_unit_chk.sv
module insn_exec_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] insn_i,
    input logic [31:0] rs_val_i,
    input logic [31:0] rt_val_i,
    input logic [31:0] result_o,
    input logic [4:0]  dest_o,
    input logic        wr_en_o,
    input logic        illegal_o
);

    // R1: first cycle out of reset shows cleared outputs
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (result_o == 32'h0 && dest_o == 5'd0 && !wr_en_o && !illegal_o));

    // R10: never a write to r0
    a_r10_no_r0_write: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (dest_o != 5'd0));

    // R9: illegal outputs are quiet
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wr_en_o && result_o == 32'h0 && dest_o == 5'd0));

    // R3: register add wraps, one cycle later
    a_r3_add_wrap: assert property (@(posedge clk) disable iff (rst)
        (insn_i[31:26] == 6'h00 && insn_i[5:0] == 6'h21)
        |=> (result_o == $past(rs_val_i + rt_val_i) && !illegal_o));

    // R7: zero-extended immediate AND never sets upper half
    a_r7_andi_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (insn_i[31:26] == 6'h0C) |=> (result_o[31:16] == 16'h0));

    // R8: upper-immediate placement
    a_r8_upper_imm: assert property (@(posedge clk) disable iff (rst)
        (insn_i[31:26] == 6'h0F) |=> (result_o == {$past(insn_i[15:0]), 16'h0}));

    // R6: immediate forms target the rt field
    a_r6_imm_dest: assert property (@(posedge clk) disable iff (rst)
        (insn_i[31:26] == 6'h09) |=> (dest_o == $past(insn_i[20:16])));

endmodule

bind insn_exec_unit insn_exec_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .insn_i    (insn_i),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .result_o  (result_o),
    .dest_o    (dest_o),
    .wr_en_o   (wr_en_o),
    .illegal_o (illegal_o)
);

// File: tb/insn_exec_unit_bench.sv
module insn_exec_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] result;
    logic [4:0]  dest;
    logic        wr_en;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_exec_unit u_insn_exec_unit (
        .clk       (clk),
        .rst       (rst),
        .insn_i    (insn),
        .rs_val_i  (rs_val),
        .rt_val_i  (rt_val),
        .result_o  (result),
        .dest_o    (dest),
        .wr_en_o   (wr_en),
        .illegal_o (illegal)
    );

    // behavioural reference: returns {illegal, wr, dest, result}
    function automatic logic [38:0] model(input logic [31:0] w, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] r;
        logic [4:0]  d;
        bit          ok;
        int          sh;
        logic [31:0] imm_s;
        logic [31:0] imm_z;
        ok    = 1;
        sh    = int'(w[10:6]);
        imm_s = {{16{w[15]}}, w[15:0]};
        imm_z = {16'h0, w[15:0]};
        d     = w[20:16];
        r     = 0;
        if (w[31:26] == 6'h00) begin
            d = w[15:11];
            case (w[5:0])
                6'h21: r = a + b;
                6'h23: r = a - b;
                6'h25: r = a | b;
                6'h26: r = a ^ b;
                6'h27: r = ~(a | b);
                6'h00: r = b << sh;
                6'h02: r = b >> sh;
                6'h03: r = $signed(b) >>> sh;
                default: ok = 0;
            endcase
        end else if (w[31:26] == 6'h09) r = a + imm_s;
        else if (w[31:26] == 6'h0C) r = a & imm_z;
        else if (w[31:26] == 6'h0D) r = a | imm_z;
        else if (w[31:26] == 6'h0F) r = w[15:0] * 32'h10000;
        else ok = 0;
        if (!ok) return {1'b1, 1'b0, 5'd0, 32'd0};
        return {1'b0, (d != 0), d, r};
    endfunction

    task automatic compare(input string tag, input logic [38:0] exp);
        logic [38:0] act;
        act = {illegal, wr_en, dest, result};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual ill=%0b wr=%0b dst=%0d res=%08h expected ill=%0b wr=%0b dst=%0d res=%08h",
                     tag, act[38], act[37], act[36:32], act[31:0],
                     exp[38], exp[37], exp[36:32], exp[31:0]);
        end
    endtask

    // drive at falling edge, result registered at next rising edge, sample at following falling edge
    task automatic run(input string tag, input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b);
        logic [38:0] exp_q [$];
        insn = w; rs_val = a; rt_val = b;
        exp_q.push_back(model(w, a, b));
        @(negedge clk);
        compare(tag, exp_q.pop_front());
    endtask

    function automatic logic [31:0] rr(input logic [4:0] rd, input logic [5:0] fn,
                                       input logic [4:0] sh);
        return {6'h00, 5'd1, 5'd2, rd, sh, fn};
    endfunction

    function automatic logic [31:0] im(input logic [5:0] opc, input logic [4:0] rt,
                                       input logic [15:0] imm);
        return {opc, 5'd3, rt, imm};
    endfunction

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2: watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        insn = rr(5'd7, 6'h21, 5'd0); rs_val = 32'hFFFF_FFFF; rt_val = 32'h1;
        @(negedge clk);
        compare("R1 reset", {1'b0, 1'b0, 5'd0, 32'd0});
        rst = 1'b0;
        @(negedge clk);
        // R2: first result after reset is the instruction held during release
        compare("R2 latency", model(insn, rs_val, rt_val));

        run("R3 add wrap", rr(5'd4, 6'h21, 5'd0), 32'hFFFF_FFF0, 32'h0000_0020);
        run("R3 sub wrap", rr(5'd4, 6'h23, 5'd0), 32'h0000_0001, 32'h0000_0002);
        run("R3 sub plain", rr(5'd9, 6'h23, 5'd3), 32'h1234_5678, 32'h0000_1111);
        run("R4 or", rr(5'd5, 6'h25, 5'd0), 32'hF0F0_0000, 32'h0000_0F0F);
        run("R4 xor", rr(5'd6, 6'h26, 5'd0), 32'hAAAA_5555, 32'hFFFF_0000);
        run("R4 nor", rr(5'd31, 6'h27, 5'd0), 32'h0F00_0001, 32'h0000_1000);
        run("R5 shl 31", rr(5'd8, 6'h00, 5'd31), 32'h0, 32'h0000_0003);
        run("R5 shl 0", rr(5'd8, 6'h00, 5'd0), 32'h0, 32'hDEAD_BEEF);
        run("R5 shrl neg", rr(5'd8, 6'h02, 5'd4), 32'h0, 32'h8000_00F0);
        run("R5 shra neg", rr(5'd8, 6'h03, 5'd4), 32'h0, 32'h8000_00F0);
        run("R5 shra 31", rr(5'd8, 6'h03, 5'd31), 32'h0, 32'h8000_0000);
        run("R5 shra pos", rr(5'd8, 6'h03, 5'd1), 32'h0, 32'h4000_0002);
        run("R6 addimm neg", im(6'h09, 5'd10, 16'hFFFF), 32'h0000_0005, 32'h0);
        run("R6 addimm pos", im(6'h09, 5'd11, 16'h7FFF), 32'hFFFF_8001, 32'h0);
        run("R7 andimm", im(6'h0C, 5'd12, 16'h8F0F), 32'hFFFF_FFFF, 32'h0);
        run("R7 orimm", im(6'h0D, 5'd13, 16'h8000), 32'h0000_0001, 32'h0);
        run("R8 upper", im(6'h0F, 5'd14, 16'hDEAD), 32'hFFFF_FFFF, 32'h0);
        run("R9 trap add func", rr(5'd4, 6'h20, 5'd0), 32'h1, 32'h2);
        run("R9 jr func", rr(5'd4, 6'h08, 5'd0), 32'h1, 32'h2);
        run("R9 load opcode", im(6'h23, 5'd4, 16'h0004), 32'h1, 32'h2);
        run("R9 branch opcode", im(6'h04, 5'd4, 16'h0004), 32'h1, 32'h2);
        run("R10 rr to r0", rr(5'd0, 6'h21, 5'd0), 32'h10, 32'h20);
        run("R10 imm to r0", im(6'h0D, 5'd0, 16'h00FF), 32'h0, 32'h0);

        begin
            logic [5:0] opcs [6];
            logic [5:0] fns [9];
            opcs = '{6'h00, 6'h09, 6'h0C, 6'h0D, 6'h0F, 6'h2B};
            fns  = '{6'h21, 6'h23, 6'h25, 6'h26, 6'h27, 6'h00, 6'h02, 6'h03, 6'h22};
            for (int k = 0; k < 400; k++) begin
                logic [31:0] w;
                w = $urandom;
                w[31:26] = opcs[$urandom_range(0, 5)];
                w[5:0]   = (w[31:26] == 6'h00) ? fns[$urandom_range(0, 8)] : w[5:0];
                run("R2 random stream", w, $urandom, $urandom);
            end
        end

        // R1: reset mid-stream clears outputs
        insn = im(6'h0F, 5'd5, 16'h1234); rst = 1'b1;
        @(negedge clk);
        compare("R1 reset again", {1'b0, 1'b0, 5'd0, 32'd0});
        rst = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule